// File: doc/BRIEF.md
# WRAP-to-INCR AXI Read Burst Adapter

This block sits on an AXI4 path between a master that issues every read burst as a wrapping burst and a slave that can only serve incrementing bursts. Each accepted read is re-issued downstream as an INCR burst covering one whole 32-byte line. The block then hands the four 64-bit beats back to the master in the wrapping order it asked for. A read whose start lies on the line boundary is streamed straight through. A read that starts at a later beat of the line is first gathered into a four-entry line buffer and then replayed, starting at the requested beat and wrapping round.

The write address, write data and write response channels have no logic in them. They are wired across, so those channels keep their own timing and handshakes. The adapter serves one read at a time. Any read it cannot map onto a full-width four-beat wrap is answered locally with an error response and never reaches the slave.

All five channels are valid/ready. A beat moves only in a cycle where valid and ready are both high. Once the adapter raises `s_rvalid` from its own buffer or its error path, it holds the beat until `s_rready` is seen. In pass-through mode, upstream back-pressure on `s_rready` reaches `m_rready` in the same cycle.

Top module: `wrap_rd_adapter`

## Requirements
- R1: Every read issued on the downstream port carries burst type INCR (2'b01), length field 3 (four beats), size field 3 (8 bytes per beat) and the ID the master supplied. `m_araddr` and `m_arvalid` hold steady until `m_arready` is seen.
- R2: A valid read whose address bits [4:0] are zero is forwarded with the same address. Downstream beats pass straight to the master in arrival order, with their data, response and RLAST unchanged.
- R3: A valid read whose address bits [4:3] are not zero is forwarded with address bits [4:0] cleared.
- R4: For such a read, no beat is offered to the master until all four downstream beats have been accepted. Beat j returned to the master is downstream beat (addr[4:3] + j) mod 4, and `s_rlast` is high on the fourth returned beat only.
- R5: In the reordered case, each beat's response code stays with its data.
- R6: A read is invalid if any of these holds: address bits [2:0] are not zero, ARLEN is not 3, ARSIZE is not 3, or ARBURST is not WRAP (2'b10). It is answered with ARLEN+1 beats of zero data and response SLVERR (2'b10), with `s_rlast` on the final beat, and nothing is issued downstream.
- R7: `s_arready` is high when no read is in progress. It stays low from the cycle after acceptance until the master has taken the last beat of that read, and is high again in the next cycle.
- R8: All write-channel outputs on either side equal their counterpart inputs in the same cycle, AWBURST included.
- R9: While `s_rready` is low, a beat offered from the line buffer or the error path keeps `s_rvalid`, `s_rdata`, `s_rresp` and `s_rlast` unchanged. In pass-through mode, `m_rready` equals `s_rready`.
- R10: Every beat returned to the master carries on `s_rid` the ID of the read being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awid | input | ID_W | Write address ID from master |
| s_awaddr | input | ADDR_W | Write address from master |
| s_awlen | input | 8 | Write burst length from master |
| s_awsize | input | 3 | Write beat size from master |
| s_awburst | input | 2 | Write burst type from master |
| s_awvalid | input | 1 | Write address valid from master |
| s_awready | output | 1 | Write address ready to master |
| s_wdata | input | DATA_W | Write data from master |
| s_wstrb | input | DATA_W/8 | Write strobes from master |
| s_wlast | input | 1 | Last write beat from master |
| s_wvalid | input | 1 | Write data valid from master |
| s_wready | output | 1 | Write data ready to master |
| s_bid | output | ID_W | Write response ID to master |
| s_bresp | output | 2 | Write response to master |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Write response ready from master |
| s_arid | input | ID_W | Read ID from master |
| s_araddr | input | ADDR_W | Read start address from master |
| s_arlen | input | 8 | Read burst length from master |
| s_arsize | input | 3 | Read beat size from master |
| s_arburst | input | 2 | Read burst type from master |
| s_arvalid | input | 1 | Read address valid from master |
| s_arready | output | 1 | Read address ready to master |
| s_rid | output | ID_W | Read data ID to master |
| s_rdata | output | DATA_W | Read data to master |
| s_rresp | output | 2 | Read response to master |
| s_rlast | output | 1 | Last read beat to master |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Read data ready from master |
| m_awid | output | ID_W | Write address ID to slave |
| m_awaddr | output | ADDR_W | Write address to slave |
| m_awlen | output | 8 | Write burst length to slave |
| m_awsize | output | 3 | Write beat size to slave |
| m_awburst | output | 2 | Write burst type to slave |
| m_awvalid | output | 1 | Write address valid to slave |
| m_awready | input | 1 | Write address ready from slave |
| m_wdata | output | DATA_W | Write data to slave |
| m_wstrb | output | DATA_W/8 | Write strobes to slave |
| m_wlast | output | 1 | Last write beat to slave |
| m_wvalid | output | 1 | Write data valid to slave |
| m_wready | input | 1 | Write data ready from slave |
| m_bid | input | ID_W | Write response ID from slave |
| m_bresp | input | 2 | Write response from slave |
| m_bvalid | input | 1 | Write response valid from slave |
| m_bready | output | 1 | Write response ready to slave |
| m_arid | output | ID_W | Read ID to slave |
| m_araddr | output | ADDR_W | Line-aligned read address to slave |
| m_arlen | output | 8 | Read burst length to slave (always 3) |
| m_arsize | output | 3 | Read beat size to slave (always 3) |
| m_arburst | output | 2 | Read burst type to slave (always INCR) |
| m_arvalid | output | 1 | Read address valid to slave |
| m_arready | input | 1 | Read address ready from slave |
| m_rdata | input | DATA_W | Read data from slave |
| m_rresp | input | 2 | Read response from slave |
| m_rlast | input | 1 | Last read beat from slave |
| m_rvalid | input | 1 | Read data valid from slave |
| m_rready | output | 1 | Read data ready to slave |

## Verification
Two functions can fall in the same cycle: the wired-across write channels and the read path while it is filling, replaying or streaming a burst. Three more pairs also coincide: the downstream slave delivering a beat while the master withholds `s_rready`, the final beat handshake while `s_arready` is about to reopen, and the line buffer being filled while the master is kept waiting. To provoke these overlaps, the bench changes every write-channel input on every cycle while it sweeps all 32 byte offsets of a line. That sweep is repeated with idle gaps on the downstream side and three upstream ready patterns. Each returned beat is compared with a value computed arithmetically from its line address and the expected wrap position. The write outputs are compared with their inputs on every cycle of the run.

// File: rtl/wrap_rd_pkg.sv
`timescale 1ns/1ps
package wrap_rd_pkg;
  localparam int          LEN_W       = 8;
  localparam logic [1:0]  BURST_INCR  = 2'b01;
  localparam logic [1:0]  BURST_WRAP  = 2'b10;
  localparam logic [1:0]  RESP_OKAY   = 2'b00;
  localparam logic [1:0]  RESP_SLVERR = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,   // accepting a new read
    ST_ADDR,   // presenting the INCR request downstream
    ST_PASS,   // line-aligned: beats stream through
    ST_FILL,   // mid-line start: gathering the line
    ST_DRAIN,  // replaying the gathered line in wrap order
    ST_ERR     // answering an unsupported read locally
  } rd_state_e;
endpackage

// File: rtl/wrap_rd_linebuf.sv
`timescale 1ns/1ps
module wrap_rd_linebuf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_resp,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_resp
);
  logic [DATA_W-1:0] slot_data [BEATS];
  logic [1:0]        slot_resp [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_data[g] <= '0;
        slot_resp[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        slot_data[g] <= wr_data;
        slot_resp[g] <= wr_resp;
      end
    end
  end

  assign rd_data = slot_data[rd_idx];
  assign rd_resp = slot_resp[rd_idx];
endmodule

// File: rtl/wrap_rd_ctl.sv
`timescale 1ns/1ps
module wrap_rd_ctl
  import wrap_rd_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int ID_W           = 4,
  parameter int BEATS          = 4,
  parameter int BYTES_PER_BEAT = 8,
  localparam int IDX_W    = $clog2(BEATS),
  localparam int OFF_LSB  = $clog2(BYTES_PER_BEAT),
  localparam int LINE_LSB = $clog2(BEATS * BYTES_PER_BEAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  input  logic [ID_W-1:0]   ar_id,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              dn_valid,
  input  logic              dn_last,
  input  logic              up_ready,
  output rd_state_e         state,
  output logic [LEN_W-1:0]  beat_cnt,
  output logic [IDX_W-1:0]  start_idx,
  output logic [ID_W-1:0]   id_q,
  output logic              beat_last
);
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              req_bad;
  logic              ar_fire;

  assign ar_ready  = (state == ST_IDLE);
  assign ar_fire   = ar_valid && ar_ready;
  assign fwd_valid = (state == ST_ADDR);
  assign fwd_addr  = base_q;

  assign req_bad = (ar_addr[OFF_LSB-1:0] != '0)
                || (ar_len   != LEN_W'(BEATS - 1))
                || (ar_size  != 3'(OFF_LSB))
                || (ar_burst != BURST_WRAP);

  assign beat_last = ((state == ST_DRAIN) && (beat_cnt == LEN_W'(BEATS - 1)))
                  || ((state == ST_ERR)   && (beat_cnt == len_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      base_q    <= '0;
      len_q     <= '0;
      id_q      <= '0;
      start_idx <= '0;
      beat_cnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ar_fire) begin
          base_q    <= {ar_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
          start_idx <= ar_addr[LINE_LSB-1:OFF_LSB];
          len_q     <= ar_len;
          id_q      <= ar_id;
          beat_cnt  <= '0;
          state     <= req_bad ? ST_ERR : ST_ADDR;
        end
        ST_ADDR: if (fwd_ready) state <= (start_idx == '0) ? ST_PASS : ST_FILL;
        ST_PASS: if (dn_valid && up_ready && dn_last) state <= ST_IDLE;
        ST_FILL: if (dn_valid) begin
          if (beat_cnt == LEN_W'(BEATS - 1)) begin
            beat_cnt <= '0;
            state    <= ST_DRAIN;
          end else begin
            beat_cnt <= beat_cnt + 1'b1;
          end
        end
        ST_DRAIN, ST_ERR: if (up_ready) begin
          beat_cnt <= beat_cnt + 1'b1;
          if (beat_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a read just taken closes the address channel
  p_single_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> !ar_ready);

  // R1: downstream request is held until taken
  p_fwd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr)));
endmodule

// File: rtl/wrap_rd_adapter.sv
`timescale 1ns/1ps
module wrap_rd_adapter
  import wrap_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int BEATS  = 4,
  localparam int STRB_W   = DATA_W / 8,
  localparam int IDX_W    = $clog2(BEATS),
  localparam int LINE_LSB = $clog2(BEATS * STRB_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [2:0]        s_awsize,
  input  logic [1:0]        s_awburst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wlast,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [7:0]        s_arlen,
  input  logic [2:0]        s_arsize,
  input  logic [1:0]        s_arburst,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [ID_W-1:0]   m_bid,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic [ID_W-1:0]   m_arid,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  input  logic              m_rvalid,
  output logic              m_rready
);
  // ---------------- write side: wired across ----------------
  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = s_awlen;
  assign m_awsize  = s_awsize;
  assign m_awburst = s_awburst;
  assign m_awvalid = s_awvalid;
  assign s_awready = m_awready;
  assign m_wdata   = s_wdata;
  assign m_wstrb   = s_wstrb;
  assign m_wlast   = s_wlast;
  assign m_wvalid  = s_wvalid;
  assign s_wready  = m_wready;
  assign s_bid     = m_bid;
  assign s_bresp   = m_bresp;
  assign s_bvalid  = m_bvalid;
  assign m_bready  = s_bready;

  // ---------------- read side ----------------
  rd_state_e         st;
  logic [LEN_W-1:0]  beat_cnt;
  logic [IDX_W-1:0]  start_idx;
  logic [ID_W-1:0]   id_q;
  logic              beat_last;
  logic [DATA_W-1:0] buf_data;
  logic [1:0]        buf_resp;
  logic [IDX_W-1:0]  rd_idx;

  wrap_rd_ctl #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .BEATS(BEATS), .BYTES_PER_BEAT(STRB_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ar_valid  (s_arvalid),
    .ar_ready  (s_arready),
    .ar_addr   (s_araddr),
    .ar_len    (s_arlen),
    .ar_size   (s_arsize),
    .ar_burst  (s_arburst),
    .ar_id     (s_arid),
    .fwd_valid (m_arvalid),
    .fwd_ready (m_arready),
    .fwd_addr  (m_araddr),
    .dn_valid  (m_rvalid),
    .dn_last   (m_rlast),
    .up_ready  (s_rready),
    .state     (st),
    .beat_cnt  (beat_cnt),
    .start_idx (start_idx),
    .id_q      (id_q),
    .beat_last (beat_last)
  );

  assign m_arid    = id_q;
  assign m_arlen   = 8'(BEATS - 1);
  assign m_arsize  = 3'($clog2(STRB_W));
  assign m_arburst = BURST_INCR;

  assign rd_idx = start_idx + beat_cnt[IDX_W-1:0];

  wrap_rd_linebuf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   ((st == ST_FILL) && m_rvalid),
    .wr_idx  (beat_cnt[IDX_W-1:0]),
    .wr_data (m_rdata),
    .wr_resp (m_rresp),
    .rd_idx  (rd_idx),
    .rd_data (buf_data),
    .rd_resp (buf_resp)
  );

  assign s_rid = id_q;

  always_comb begin
    s_rvalid = 1'b0;
    s_rdata  = '0;
    s_rresp  = RESP_OKAY;
    s_rlast  = 1'b0;
    m_rready = 1'b0;
    case (st)
      ST_PASS: begin
        s_rvalid = m_rvalid;
        s_rdata  = m_rdata;
        s_rresp  = m_rresp;
        s_rlast  = m_rlast;
        m_rready = s_rready;
      end
      ST_FILL: m_rready = 1'b1;
      ST_DRAIN: begin
        s_rvalid = 1'b1;
        s_rdata  = buf_data;
        s_rresp  = buf_resp;
        s_rlast  = beat_last;
      end
      ST_ERR: begin
        s_rvalid = 1'b1;
        s_rresp  = RESP_SLVERR;
        s_rlast  = beat_last;
      end
      default: ;
    endcase
  end

  // R3: downstream requests always start on a line boundary as INCR
  p_line_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (m_araddr[LINE_LSB-1:0] == '0) && (m_arburst == BURST_INCR));

  // R4: nothing is offered upstream while the line is being gathered
  p_fill_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL) |-> !s_rvalid);

  // R7: last beat taken reopens the address channel
  p_last_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rready && s_rlast) |=> s_arready);

  // R9: locally sourced beats hold under back-pressure
  p_local_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DRAIN || st == ST_ERR) && s_rvalid && !s_rready)
      |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp) && $stable(s_rlast)));
endmodule

// File: tb/wrap_rd_adapter_tb.sv
`timescale 1ns/1ps
module wrap_rd_adapter_tb;
  localparam int ID_W = 4, ADDR_W = 32, DATA_W = 64, STRB_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [ID_W-1:0] s_awid, m_awid, s_bid, m_bid, s_arid, s_rid, m_arid;
  logic [ADDR_W-1:0] s_awaddr, m_awaddr, s_araddr, m_araddr;
  logic [7:0] s_awlen, m_awlen, s_arlen, m_arlen;
  logic [2:0] s_awsize, m_awsize, s_arsize, m_arsize;
  logic [1:0] s_awburst, m_awburst, s_arburst, m_arburst;
  logic s_awvalid, s_awready, m_awvalid, m_awready;
  logic [DATA_W-1:0] s_wdata, m_wdata, s_rdata, m_rdata;
  logic [STRB_W-1:0] s_wstrb, m_wstrb;
  logic s_wlast, s_wvalid, s_wready, m_wlast, m_wvalid, m_wready;
  logic [1:0] s_bresp, m_bresp, s_rresp, m_rresp;
  logic s_bvalid, s_bready, m_bvalid, m_bready;
  logic s_arvalid, s_arready, m_arvalid, m_arready;
  logic s_rlast, s_rvalid, s_rready, m_rlast, m_rvalid, m_rready;

  wrap_rd_adapter u_dut (.*);

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] line_word(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, ~a};
  endfunction

  // ---------------- downstream slave model ----------------
  int ar_seen = 0, sent = 0;
  bit slv_gap = 0, resp_mode = 0;
  logic [31:0] slv_addr;
  logic [7:0]  slv_len;
  logic [2:0]  slv_size;
  logic [1:0]  slv_burst;
  logic [3:0]  slv_id;

  initial begin
    bit hs;
    m_arready = 0; m_rvalid = 0; m_rlast = 0; m_rdata = '0; m_rresp = '0;
    forever begin
      @(negedge clk); #1;
      if (m_arvalid) begin
        if (slv_gap) begin @(negedge clk); #1; end
        m_arready = 1;
        slv_addr = m_araddr; slv_len = m_arlen; slv_size = m_arsize;
        slv_burst = m_arburst; slv_id = m_arid;
        ar_seen++; sent = 0;
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          m_arready = 0;
          if (slv_gap && k[0]) begin m_rvalid = 0; @(negedge clk); end
          m_rvalid = 1;
          m_rdata  = line_word(slv_addr + 32'(8 * k));
          m_rresp  = resp_mode ? 2'(k) : 2'b00;
          m_rlast  = (k == 3);
          forever begin
            #1; hs = m_rready;
            @(posedge clk);
            if (hs) break;
            @(negedge clk);
          end
          sent++;
        end
        @(negedge clk);
        m_rvalid = 0; m_rlast = 0;
      end
    end
  end

  // ---------------- write channel poker (R8) ----------------
  initial begin
    int cyc = 0;
    {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst, s_awvalid} = '0;
    {s_wdata, s_wstrb, s_wlast, s_wvalid, s_bready} = '0;
    {m_awready, m_wready, m_bid, m_bresp, m_bvalid} = '0;
    wait (rst_n);
    while (!done) begin
      @(negedge clk);
      cyc++;
      s_awid = 4'(cyc); s_awaddr = 32'(cyc * 32'h9E37_79B9);
      s_awlen = 8'(cyc * 3); s_awsize = 3'(cyc >> 2); s_awburst = 2'(cyc >> 1);
      s_awvalid = cyc[0]; s_wdata = {32'(cyc), 32'(~cyc)}; s_wstrb = 8'(cyc * 7);
      s_wlast = cyc[1]; s_wvalid = cyc[2]; s_bready = cyc[3];
      m_awready = cyc[4]; m_wready = cyc[0] ^ cyc[3]; m_bid = 4'(cyc >> 3);
      m_bresp = 2'(cyc >> 5); m_bvalid = cyc[1] ^ cyc[2];
      #2;
      check({m_awid, m_awaddr, m_awlen, m_awsize, m_awburst, m_awvalid}
              == {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst, s_awvalid},
            "R8", "aw forward", {m_awid, m_awaddr, m_awburst},
            {s_awid, s_awaddr, s_awburst});
      check({m_wdata, m_wstrb, m_wlast, m_wvalid, m_bready}
              == {s_wdata, s_wstrb, s_wlast, s_wvalid, s_bready},
            "R8", "w/bready forward", {m_wdata, m_wstrb}, {s_wdata, s_wstrb});
      check({s_awready, s_wready, s_bid, s_bresp, s_bvalid}
              == {m_awready, m_wready, m_bid, m_bresp, m_bvalid},
            "R8", "ready/b backward", {s_awready, s_wready, s_bid, s_bresp, s_bvalid},
            {m_awready, m_wready, m_bid, m_bresp, m_bvalid});
    end
  end

  // ---------------- master side read task ----------------
  int rd_seq = 0;

  task automatic do_read(input logic [31:0] a, input logic [7:0] len,
                         input logic [2:0] size, input logic [1:0] burst,
                         input int stall);
    logic [3:0]  id;
    logic [31:0] base;
    logic [1:0]  idx;
    bit bad, hs, arr_low;
    int nbeats, ar_before, j, cyc;
    string tag;
    id = 4'(rd_seq); rd_seq++;
    bad = (a[2:0] != 0) || (len != 8'd3) || (size != 3'd3) || (burst != 2'b10);
    base = {a[31:5], 5'b0};
    idx = a[4:3];
    nbeats = bad ? int'(len) + 1 : 4;
    tag = bad ? "R6" : (idx == 0 ? "R2" : (resp_mode ? "R5" : "R4"));
    ar_before = ar_seen;
    arr_low = 1;

    @(negedge clk);
    s_arvalid = 1; s_araddr = a; s_arlen = len; s_arsize = size;
    s_arburst = burst; s_arid = id;
    forever begin
      #1; hs = s_arready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end

    j = 0; cyc = 0;
    while (j < nbeats) begin
      @(negedge clk);
      s_arvalid = 0;
      s_rready = (stall == 0) ? 1'b1 : (stall == 1) ? cyc[0] : ((cyc % 4) == 3);
      cyc++;
      #1;
      if (s_arready) arr_low = 0;
      if (s_rvalid && s_rready) begin
        logic [1:0]  k;
        logic [63:0] ed;
        logic [1:0]  er;
        k  = idx + 2'(j);
        ed = bad ? 64'd0 : line_word(base + 32'(8 * k));
        er = bad ? 2'b10 : (resp_mode ? k : 2'b00);
        if (!bad && idx != 0 && j == 0)
          check(sent == 4, "R4", "line gathered before first beat", 128'(sent), 128'd4);
        check({s_rid, s_rresp, s_rlast, s_rdata} == {id, er, (j == nbeats - 1), ed},
              tag, "beat (R10 id)", {s_rid, s_rresp, s_rlast, s_rdata},
              {id, er, (j == nbeats - 1), ed});
        j++;
      end
      @(posedge clk);
    end

    @(negedge clk);
    s_rready = 0;
    #1;
    check(arr_low && s_arready, "R7", "arready low during read, high after",
          {arr_low, s_arready}, 2'b11);
    if (bad)
      check(ar_seen == ar_before, "R6", "no downstream request",
            128'(ar_seen), 128'(ar_before));
    else begin
      check(ar_seen == ar_before + 1, "R1", "one downstream request",
            128'(ar_seen), 128'(ar_before + 1));
      check({slv_addr, slv_len, slv_size, slv_burst, slv_id}
              == {base, 8'd3, 3'd3, 2'b01, id},
            "R1 R3", "forwarded request",
            {slv_addr, slv_len, slv_size, slv_burst, slv_id},
            {base, 8'd3, 3'd3, 2'b01, id});
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    s_arvalid = 0; s_araddr = '0; s_arlen = '0; s_arsize = '0;
    s_arburst = '0; s_arid = '0; s_rready = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check({s_arready, s_rvalid, m_arvalid} == 3'b100, "R7", "reset state",
          {s_arready, s_rvalid, m_arvalid}, 3'b100);

    // full offset sweep: gaps, ready patterns, response tagging
    for (int rm = 0; rm < 2; rm++)
      for (int g = 0; g < 2; g++)
        for (int st = 0; st < 3; st++)
          for (int off = 0; off < 32; off++) begin
            resp_mode = rm[0];
            slv_gap = g[0];
            do_read(32'h1000_0000 + 32'((rm * 6 + g * 3 + st) * 64) + 32'(off),
                    8'd3, 3'd3, 2'b10, st);
          end

    // unsupported shapes (R6), with and without back-pressure
    resp_mode = 0;
    for (int st = 0; st < 3; st++) begin
      do_read(32'h2000_0040, 8'd0,  3'd3, 2'b10, st);
      do_read(32'h2000_0048, 8'd1,  3'd3, 2'b10, st);
      do_read(32'h2000_0050, 8'd7,  3'd3, 2'b10, st);
      do_read(32'h2000_0060, 8'd3,  3'd2, 2'b10, st);
      do_read(32'h2000_0068, 8'd3,  3'd3, 2'b01, st);
      do_read(32'h2000_0071, 8'd15, 3'd3, 2'b10, st);
    end

    // R9: pass-through ready mapping
    @(negedge clk); s_rready = 1; #1;
    check(m_rready == 1'b0, "R9", "idle m_rready", m_rready, 1'b0);
    s_rready = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule